// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Front End

This block sits between a byte-wide processor bus and the rest of a two-channel serial controller. The bus has a 4-bit address, separate active-low read and write strobes, and an 8-bit data path. Both strobes are brought into the clock domain through a synchronizer. Each strobe assertion then acts exactly once, on the clock after the synchronized strobe becomes active. The same address can name one register when read and a different one when written. Some addresses hold no storage at all and act as commands.

Each channel has two mode bytes that share one address. A pointer inside each channel selects between them. The first access, read or write, lands on mode byte 1. Every later access lands on mode byte 2. A pointer-reset command written to that channel's command register returns the pointer to mode byte 1. The serial engines, the counter/timer and the baud logic are outside this block. They connect through plain data inputs (status, receive data, counter value, pins) and through plain strobe and register outputs. The bus is strobe-timed, so it has no back-pressure and no valid/ready pair. The processor must hold the address and write data stable while its strobe is low.

Top module: `duart_regif`

## Requirements
- R1: After reset every stored register (mode bytes, clock selects, auxiliary control, interrupt mask, preset bytes, output configuration, output bits, command and transmit bytes) reads 0. Both pointers select mode byte 1, all strobes are low and rdata is 0x00.
- R2: Reads and writes at address 0x0 (channel A) and 0x8 (channel B) reach mode byte 1 when the pointer is there, and every such access moves the pointer to mode byte 2. The pointer then stays on mode byte 2, so later writes update only mode byte 2.
- R3: A write to the command address (0x2 for A, 0xA for B) gives a one-clock cmd_stb for that channel, and cmd_q holds the byte. If bits [6:4] of the byte equal 3'b001, the pointer of that channel returns to mode byte 1. Any other code leaves the pointer where it is.
- R4: The two channels keep separate pointers and separate registers. An access to one channel never changes the other.
- R5: Reads return: 0x1/0x9 channel status, 0x3/0xB channel receive data, 0x4 input-change byte, 0x5 interrupt status, 0x6/0x7 counter high/low byte, and 0xD the 7 input pins with bit 7 read as 0.
- R6: Writes store: 0x1/0x9 clock select, 0x4 auxiliary control, 0x5 interrupt mask, 0x6/0x7 preset high/low, 0xD output configuration. A write at 0x3/0xB gives a one-clock tx_stb for that channel, and txd_q holds the byte.
- R7: A read at 0x3/0xB gives a one-clock rx_pop for that channel.
- R8: A read at 0xE gives a one-clock cnt_start and a read at 0xF gives a one-clock cnt_stop. Both of these reads return 0x00.
- R9: A write at 0xE sets each bit of opout_q where the data bit is 1. A write at 0xF clears each bit where the data bit is 1. Bits written as 0 keep their value.
- R10: Reads at 0x2, 0xA and 0xC return 0x00 and raise no strobe. A write at 0xC changes no register and raises no strobe.
- R11: An access produces its effects once, however long the strobe is held low. At most one strobe output is high in any cycle.
- R12: A mode-address read returns the mode byte the pointer selected before that read moved it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, held from the last read |
| stat_in | input | 2x8 | Per-channel status byte |
| rxd_in | input | 2x8 | Per-channel received byte |
| ipchg_in | input | 8 | Input-change byte |
| irq_stat_in | input | 8 | Interrupt status byte |
| cnt_hi_in | input | 8 | Counter value, high byte |
| cnt_lo_in | input | 8 | Counter value, low byte |
| pins_in | input | 7 | Input pins |
| mode1_q | output | 2x8 | Mode byte 1 per channel |
| mode2_q | output | 2x8 | Mode byte 2 per channel |
| clksel_q | output | 2x8 | Clock select per channel |
| acr_q | output | 8 | Auxiliary control |
| imr_q | output | 8 | Interrupt mask |
| preset_hi_q | output | 8 | Counter preset high byte |
| preset_lo_q | output | 8 | Counter preset low byte |
| opcfg_q | output | 8 | Output configuration |
| opout_q | output | 8 | Output bits |
| cmd_stb | output | 2 | Per-channel command pulse |
| cmd_q | output | 2x8 | Last command byte per channel |
| tx_stb | output | 2 | Per-channel transmit pulse |
| txd_q | output | 2x8 | Last transmit byte per channel |
| rx_pop | output | 2 | Per-channel receive-pop pulse |
| cnt_start | output | 1 | Counter start pulse |
| cnt_stop | output | 1 | Counter stop pulse |

## Verification
The pointer is driven with a run of mode writes followed by reads. This shows whether the first access takes mode byte 1 and whether every later one sticks on mode byte 2. Pointer-reset and non-reset command codes are interleaved with mode reads, which tells a real pointer reset apart from a command that merely pulses. It also checks that the read returns the byte selected before the pointer moved. Set/clear writes with overlapping masks tell true bit-wise set and clear apart from plain overwrites. Held strobes, reserved addresses and accesses to the other channel show whether an effect repeats, leaks into a reserved slot, or crosses between channels.

// File: rtl/duart_regif_pkg.sv
package duart_regif_pkg;
  localparam logic [3:0] AD_MODE_A = 4'h0;
  localparam logic [3:0] AD_CSR_A  = 4'h1;
  localparam logic [3:0] AD_CMD_A  = 4'h2;
  localparam logic [3:0] AD_DAT_A  = 4'h3;
  localparam logic [3:0] AD_AUX    = 4'h4;
  localparam logic [3:0] AD_IRQ    = 4'h5;
  localparam logic [3:0] AD_CNT_HI = 4'h6;
  localparam logic [3:0] AD_CNT_LO = 4'h7;
  localparam logic [3:0] AD_MODE_B = 4'h8;
  localparam logic [3:0] AD_CSR_B  = 4'h9;
  localparam logic [3:0] AD_CMD_B  = 4'hA;
  localparam logic [3:0] AD_DAT_B  = 4'hB;
  localparam logic [3:0] AD_RSVD   = 4'hC;
  localparam logic [3:0] AD_PINS   = 4'hD;
  localparam logic [3:0] AD_SET    = 4'hE;
  localparam logic [3:0] AD_CLR    = 4'hF;

  // Offsets inside one channel's block of four addresses
  localparam logic [1:0] CH_MODE = 2'd0;
  localparam logic [1:0] CH_CSR  = 2'd1;
  localparam logic [1:0] CH_CMD  = 2'd2;
  localparam logic [1:0] CH_DAT  = 2'd3;

  // Command field value that returns the mode pointer to byte 1
  localparam logic [2:0] CMD_PTR_HOME = 3'b001;
endpackage

// File: rtl/duart_strobe_sync.sv
module duart_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic pulse
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], ~strobe_n};
      prev <= sh[STAGES-1];
    end
  end

  assign pulse = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/duart_mode_ptr.sv
module duart_mode_ptr #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          access,
  input  logic          wr_en,
  input  logic          ptr_home,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mr1,
  output logic [DW-1:0] mr2,
  output logic          at_mr2,
  output logic [DW-1:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1    <= '0;
      mr2    <= '0;
      at_mr2 <= 1'b0;
    end else begin
      if (wr_en) begin
        if (at_mr2) mr2 <= wdata;
        else        mr1 <= wdata;
      end
      if (ptr_home)    at_mr2 <= 1'b0;
      else if (access) at_mr2 <= 1'b1;
    end
  end

  assign rd_val = at_mr2 ? mr2 : mr1;
endmodule

// File: rtl/duart_outport.sv
module duart_outport #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end
endmodule

// File: rtl/duart_regif.sv
module duart_regif
  import duart_regif_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned PIN_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          addr,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic [1:0][DW-1:0]  stat_in,
  input  logic [1:0][DW-1:0]  rxd_in,
  input  logic [DW-1:0]       ipchg_in,
  input  logic [DW-1:0]       irq_stat_in,
  input  logic [DW-1:0]       cnt_hi_in,
  input  logic [DW-1:0]       cnt_lo_in,
  input  logic [PIN_W-1:0]    pins_in,
  output logic [1:0][DW-1:0]  mode1_q,
  output logic [1:0][DW-1:0]  mode2_q,
  output logic [1:0][DW-1:0]  clksel_q,
  output logic [DW-1:0]       acr_q,
  output logic [DW-1:0]       imr_q,
  output logic [DW-1:0]       preset_hi_q,
  output logic [DW-1:0]       preset_lo_q,
  output logic [DW-1:0]       opcfg_q,
  output logic [DW-1:0]       opout_q,
  output logic [1:0]          cmd_stb,
  output logic [1:0][DW-1:0]  cmd_q,
  output logic [1:0]          tx_stb,
  output logic [1:0][DW-1:0]  txd_q,
  output logic [1:0]          rx_pop,
  output logic                cnt_start,
  output logic                cnt_stop
);
  localparam int unsigned NCH = 2;

  logic rd_p, wr_p;
  logic [NCH-1:0]         ptr_at2;
  logic [NCH-1:0][DW-1:0] mode_rd;
  logic [DW-1:0]          rd_mux;

  duart_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .pulse(rd_p)
  );
  duart_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .pulse(wr_p)
  );

  // Per-channel register block: address bit 3 picks the channel, bit 2 low
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          in_blk;
    logic          mode_acc;
    logic          home;
    logic [DW-1:0] csr_r, cmd_r, txd_r;
    logic          cmd_p, tx_p, rx_p;

    assign in_blk   = (addr[3] == 1'(c)) && !addr[2];
    assign mode_acc = in_blk && (addr[1:0] == CH_MODE) && (rd_p || wr_p);
    assign home     = in_blk && (addr[1:0] == CH_CMD) && wr_p &&
                      (wdata[6:4] == CMD_PTR_HOME);

    duart_mode_ptr #(.DW(DW)) u_mode (
      .clk(clk), .rst_n(rst_n),
      .access(mode_acc), .wr_en(mode_acc && wr_p), .ptr_home(home),
      .wdata(wdata),
      .mr1(mode1_q[c]), .mr2(mode2_q[c]),
      .at_mr2(ptr_at2[c]), .rd_val(mode_rd[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        csr_r <= '0;
        cmd_r <= '0;
        txd_r <= '0;
        cmd_p <= 1'b0;
        tx_p  <= 1'b0;
        rx_p  <= 1'b0;
      end else begin
        cmd_p <= in_blk && wr_p && (addr[1:0] == CH_CMD);
        tx_p  <= in_blk && wr_p && (addr[1:0] == CH_DAT);
        rx_p  <= in_blk && rd_p && (addr[1:0] == CH_DAT);
        if (in_blk && wr_p) begin
          case (addr[1:0])
            CH_CSR:  csr_r <= wdata;
            CH_CMD:  cmd_r <= wdata;
            CH_DAT:  txd_r <= wdata;
            default: ;
          endcase
        end
      end
    end

    assign clksel_q[c] = csr_r;
    assign cmd_q[c]    = cmd_r;
    assign txd_q[c]    = txd_r;
    assign cmd_stb[c]  = cmd_p;
    assign tx_stb[c]   = tx_p;
    assign rx_pop[c]   = rx_p;
  end

  // Shared registers and counter commands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acr_q       <= '0;
      imr_q       <= '0;
      preset_hi_q <= '0;
      preset_lo_q <= '0;
      opcfg_q     <= '0;
      cnt_start   <= 1'b0;
      cnt_stop    <= 1'b0;
    end else begin
      cnt_start <= rd_p && (addr == AD_SET);
      cnt_stop  <= rd_p && (addr == AD_CLR);
      if (wr_p) begin
        case (addr)
          AD_AUX:    acr_q       <= wdata;
          AD_IRQ:    imr_q       <= wdata;
          AD_CNT_HI: preset_hi_q <= wdata;
          AD_CNT_LO: preset_lo_q <= wdata;
          AD_PINS:   opcfg_q     <= wdata;
          default:   ;
        endcase
      end
    end
  end

  duart_outport #(.DW(DW)) u_outport (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_p && (addr == AD_SET)),
    .clr_en(wr_p && (addr == AD_CLR)),
    .mask(wdata), .q(opout_q)
  );

  // Read data selection; reserved and command-only addresses give zero
  always_comb begin
    case (addr)
      AD_MODE_A: rd_mux = mode_rd[0];
      AD_CSR_A:  rd_mux = stat_in[0];
      AD_DAT_A:  rd_mux = rxd_in[0];
      AD_AUX:    rd_mux = ipchg_in;
      AD_IRQ:    rd_mux = irq_stat_in;
      AD_CNT_HI: rd_mux = cnt_hi_in;
      AD_CNT_LO: rd_mux = cnt_lo_in;
      AD_MODE_B: rd_mux = mode_rd[1];
      AD_CSR_B:  rd_mux = stat_in[1];
      AD_DAT_B:  rd_mux = rxd_in[1];
      AD_PINS:   rd_mux = DW'(pins_in);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (rd_p) rdata <= rd_mux;
  end
endmodule

// File: rtl/duart_regif_chk.sv
module duart_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ptr_at2,
  input logic [1:0] cmd_stb,
  input logic [1:0] tx_stb,
  input logic [1:0] rx_pop,
  input logic       cnt_start,
  input logic       cnt_stop
);
  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_start |=> !cnt_start);
  // R11
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_stop |=> !cnt_stop);
  // R11
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb != 2'b00) |=> (tx_stb == 2'b00));
  // R11
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop != 2'b00) |=> (rx_pop == 2'b00));
  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb != 2'b00) |=> (cmd_stb == 2'b00));
  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_stb, tx_stb, rx_pop, cnt_start, cnt_stop}) <= 1);
  // R3
  ptr_home_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptr_at2[0]) |-> cmd_stb[0]);
  // R3
  ptr_home_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptr_at2[1]) |-> cmd_stb[1]);
endmodule

bind duart_regif duart_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_at2(ptr_at2),
  .cmd_stb(cmd_stb), .tx_stb(tx_stb), .rx_pop(rx_pop),
  .cnt_start(cnt_start), .cnt_stop(cnt_stop)
);

// File: tb/duart_regif_bench.sv
module duart_regif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0][7:0] stat_in = '0, rxd_in = '0;
  logic [7:0] ipchg_in = '0, irq_stat_in = '0, cnt_hi_in = '0, cnt_lo_in = '0;
  logic [6:0] pins_in = '0;
  logic [1:0][7:0] mode1_q, mode2_q, clksel_q, cmd_q, txd_q;
  logic [7:0] acr_q, imr_q, preset_hi_q, preset_lo_q, opcfg_q, opout_q;
  logic [1:0] cmd_stb, tx_stb, rx_pop;
  logic cnt_start, cnt_stop;

  always #5 clk = ~clk;

  duart_regif u_duart_regif (.*);

  typedef enum logic [2:0] {EV_CMD, EV_TX, EV_RX, EV_START, EV_STOP} ev_kind_t;
  typedef struct packed { ev_kind_t kind; logic ch; logic [7:0] data; } ev_t;
  ev_t exp_q[$];
  int nrun = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input ev_kind_t k, input logic ch, input logic [7:0] d);
    exp_q.push_back('{kind: k, ch: ch, data: d});
  endtask

  task automatic got_ev(input ev_t e);
    ev_t x;
    nrun++;
    if (exp_q.size() == 0) begin
      nfail++;
      $display("FAIL R11: unexpected strobe actual %h expected none", e);
    end else begin
      x = exp_q.pop_front();
      if (x !== e) begin
        nfail++;
        $display("FAIL R3/R6/R7/R8: strobe actual %h expected %h", e, x);
      end
    end
  endtask

  // Monitor: every strobe seen must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++) begin
        if (cmd_stb[c]) got_ev('{kind: EV_CMD, ch: c[0], data: cmd_q[c]});
        if (tx_stb[c])  got_ev('{kind: EV_TX,  ch: c[0], data: txd_q[c]});
        if (rx_pop[c])  got_ev('{kind: EV_RX,  ch: c[0], data: 8'h00});
      end
      if (cnt_start) got_ev('{kind: EV_START, ch: 1'b0, data: 8'h00});
      if (cnt_stop)  got_ev('{kind: EV_STOP,  ch: 1'b0, data: 8'h00});
    end
  end

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d, input int hold = 4);
    @(negedge clk);
    addr = a; wdata = d; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 mode1 A", mode1_q[0], 8'h00);
    chk("R1 mode2 B", mode2_q[1], 8'h00);
    chk("R1 opout", opout_q, 8'h00);
    chk("R1 strobes", {cmd_stb, tx_stb, rx_pop, cnt_start, cnt_stop}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 acr", acr_q, 8'h00);

    // R2 pointer advance and stickiness
    cpu_wr(4'h0, 8'h13);
    chk("R2 first write to mode1", mode1_q[0], 8'h13);
    chk("R2 mode2 untouched", mode2_q[0], 8'h00);
    cpu_wr(4'h0, 8'h07);
    chk("R2 second write to mode2", mode2_q[0], 8'h07);
    cpu_wr(4'h0, 8'h55);
    chk("R2 stays on mode2", mode2_q[0], 8'h55);
    chk("R2 mode1 kept", mode1_q[0], 8'h13);
    cpu_rd(4'h0, d);
    chk("R12 read at mode2", d, 8'h55);

    // R3 pointer-home command, then R12 read order
    expect_ev(EV_CMD, 1'b0, 8'h10);
    cpu_wr(4'h2, 8'h10);
    cpu_rd(4'h0, d);
    chk("R12 read after home gives mode1", d, 8'h13);
    cpu_rd(4'h0, d);
    chk("R3 pointer advanced after read", d, 8'h55);
    expect_ev(EV_CMD, 1'b0, 8'h20);
    cpu_wr(4'h2, 8'h20);
    cpu_rd(4'h0, d);
    chk("R3 other code keeps pointer", d, 8'h55);

    // R4 channel B independent
    cpu_wr(4'h8, 8'h21);
    chk("R4 B first write mode1", mode1_q[1], 8'h21);
    chk("R4 A mode1 unchanged", mode1_q[0], 8'h13);
    cpu_wr(4'h8, 8'h42);
    chk("R4 B mode2", mode2_q[1], 8'h42);
    chk("R4 A mode2 unchanged", mode2_q[0], 8'h55);
    expect_ev(EV_CMD, 1'b1, 8'h1F);
    cpu_wr(4'hA, 8'h1F);
    cpu_rd(4'h8, d);
    chk("R4 B home", d, 8'h21);
    cpu_rd(4'h0, d);
    chk("R4 A pointer unaffected", d, 8'h55);

    // R5 read map
    stat_in[0] = 8'hA1; stat_in[1] = 8'hB2; rxd_in[0] = 8'hC3; rxd_in[1] = 8'hD4;
    ipchg_in = 8'h5E; irq_stat_in = 8'h6F; cnt_hi_in = 8'h12; cnt_lo_in = 8'h34;
    pins_in = 7'h7F;
    cpu_rd(4'h1, d); chk("R5 status A", d, 8'hA1);
    cpu_rd(4'h9, d); chk("R5 status B", d, 8'hB2);
    cpu_rd(4'h4, d); chk("R5 input change", d, 8'h5E);
    cpu_rd(4'h5, d); chk("R5 irq status", d, 8'h6F);
    cpu_rd(4'h6, d); chk("R5 counter hi", d, 8'h12);
    cpu_rd(4'h7, d); chk("R5 counter lo", d, 8'h34);
    cpu_rd(4'hD, d); chk("R5 pins bit7 zero", d, 8'h7F);
    // R7 receive pop with data
    expect_ev(EV_RX, 1'b0, 8'h00);
    cpu_rd(4'h3, d); chk("R5 R7 rx A", d, 8'hC3);
    expect_ev(EV_RX, 1'b1, 8'h00);
    cpu_rd(4'hB, d); chk("R5 R7 rx B", d, 8'hD4);

    // R6 write map
    cpu_wr(4'h1, 8'h66); chk("R6 clksel A", clksel_q[0], 8'h66);
    cpu_wr(4'h9, 8'h77); chk("R6 clksel B", clksel_q[1], 8'h77);
    chk("R6 clksel A kept", clksel_q[0], 8'h66);
    cpu_wr(4'h4, 8'h81); chk("R6 acr", acr_q, 8'h81);
    cpu_wr(4'h5, 8'h92); chk("R6 imr", imr_q, 8'h92);
    cpu_wr(4'h6, 8'hA3); chk("R6 preset hi", preset_hi_q, 8'hA3);
    cpu_wr(4'h7, 8'hB4); chk("R6 preset lo", preset_lo_q, 8'hB4);
    cpu_wr(4'hD, 8'hC5); chk("R6 opcfg", opcfg_q, 8'hC5);
    expect_ev(EV_TX, 1'b0, 8'h3C);
    cpu_wr(4'h3, 8'h3C);
    expect_ev(EV_TX, 1'b1, 8'hE7);
    cpu_wr(4'hB, 8'hE7);

    // R8 counter commands
    expect_ev(EV_START, 1'b0, 8'h00);
    cpu_rd(4'hE, d); chk("R8 start read zero", d, 8'h00);
    expect_ev(EV_STOP, 1'b0, 8'h00);
    cpu_rd(4'hF, d); chk("R8 stop read zero", d, 8'h00);

    // R9 output bit set/clear
    cpu_wr(4'hE, 8'h0F); chk("R9 set", opout_q, 8'h0F);
    cpu_wr(4'hE, 8'h30); chk("R9 set keeps others", opout_q, 8'h3F);
    cpu_wr(4'hF, 8'h05); chk("R9 clear", opout_q, 8'h3A);
    cpu_wr(4'hF, 8'h00); chk("R9 clear zero no change", opout_q, 8'h3A);

    // R10 reserved addresses (any strobe would fail in the monitor)
    cpu_rd(4'h2, d); chk("R10 read 2", d, 8'h00);
    cpu_rd(4'hA, d); chk("R10 read A", d, 8'h00);
    cpu_rd(4'hC, d); chk("R10 read C", d, 8'h00);
    cpu_wr(4'hC, 8'hFF);
    chk("R10 acr after write C", acr_q, 8'h81);
    chk("R10 imr after write C", imr_q, 8'h92);
    chk("R10 opcfg after write C", opcfg_q, 8'hC5);
    chk("R10 opout after write C", opout_q, 8'h3A);
    chk("R10 clksel B after write C", clksel_q[1], 8'h77);

    // R11 long strobes act once
    expect_ev(EV_TX, 1'b0, 8'h99);
    cpu_wr(4'h3, 8'h99, 20);
    cpu_wr(4'h0, 8'hAB, 20);
    chk("R11 long mode write once", mode2_q[0], 8'hAB);
    chk("R11 mode1 untouched", mode1_q[0], 8'h13);

    repeat (4) @(negedge clk);
    chk("R11 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule